// File: doc/BRIEF.md
# UART transmit queue with interrupt unit

This block is the register-facing half of a serial port. Software stores bytes one at a time through a write-data register. They collect in a transmit queue, and a downstream serial shifter takes them one at a time whenever it signals that it is ready and transmit is enabled. The block keeps the queue level current. From that level it derives the empty, idle and full status flags and a programmable level-threshold interrupt.

On the receive side there is a single holding register. Its empty and idle flags clear when a byte arrives and set again when software reads the byte. Four interrupt sources (transmit threshold, receive threshold, transmit drained, receive overrun) each drive their own output. Software can mask each source, clear it by writing ones, and force it from a test register. The register bus carries 32-bit words only. Reads return data in the same cycle, and writes take effect at the next clock edge.

Top module: `uart_txq`

## Requirements
- R1: After reset the status word (offset 0x10) reads 0x3C, every other readable register reads zero, and `irq` is 0.
- R2: `irq[i]` is high exactly when interrupt state bit i and enable bit i (offset 0x04) are both set. The bits are: 0 transmit threshold, 1 receive threshold, 2 transmit drained, 3 receive overrun.
- R3: Writing the interrupt state word (offset 0x00) clears each bit written as 1 and leaves the other bits unchanged.
- R4: Writing the interrupt test word (offset 0x08) sets each state bit written as 1.
- R5: Each write to offset 0x18 appends `wdata[7:0]` to the transmit queue. Bytes leave in the order they were written. The queue level reads from bits [5:0] at offset 0x20.
- R6: With 32 bytes held, status bit 0 (full) is set, and a further write to offset 0x18 is discarded with a one-cycle `tx_drop` pulse. This holds even if a byte leaves in the same cycle.
- R7: The threshold field sits in bits [13:8] at offset 0x1C. Interrupt bit 0 sets when a write leaves the level at or above the threshold. It clears when a departure or a flush leaves the level below it.
- R8: A byte leaves only in a cycle where control bit 0 (offset 0x0C) is set, the queue is not empty and `tx_ready` is high. When the last byte leaves, status bits 2 and 3 and interrupt bit 2 are set.
- R9: Writing offset 0x1C with bit 1 set empties the queue at once. It clears interrupt bit 0 when the new level is below the threshold, and it does not set interrupt bit 2.
- R10: A byte on `rx_valid` is taken only while control bit 1 is set. It is loaded into the holding register at offset 0x14, clears status bits 4 and 5, and sets status bit 1.
- R11: Reading offset 0x14 sets status bits 4 and 5 again. A byte taken while the holding register is occupied sets interrupt bit 3. A byte taken while the receive threshold field (bits [18:16] at offset 0x1C) is zero sets interrupt bit 1.
- R12: A queue write and a departure in the same cycle leave the level unchanged and keep the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 6 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| tx_valid | output | 1 | A byte is offered to the shifter |
| tx_byte | output | 8 | Head byte of the queue |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_drop | output | 1 | A write to a full queue was discarded |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| irq | output | 4 | Masked interrupt lines |

## Verification
The case that needs most care is a software write to the queue landing in the same cycle as a departure to the shifter. The bench provokes it by raising `tx_ready` for exactly the cycle that carries a write-data access, with two bytes already waiting. It then judges the result in two ways. The level read back must be unchanged, and the scoreboard must see the remaining bytes leave in the order they were written. The same collision at full occupancy is also driven, and the bench expects the write to be dropped with a `tx_drop` pulse.

// File: rtl/uart_txq.sv
`timescale 1ns/1ps
module uart_txq #(
  parameter int DEPTH = 32,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_ready,
  output logic          tx_drop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic [3:0]    irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;
  localparam logic [AW-1:0] A_ISTATE = AW'(6'h00);
  localparam logic [AW-1:0] A_IEN    = AW'(6'h04);
  localparam logic [AW-1:0] A_ITEST  = AW'(6'h08);
  localparam logic [AW-1:0] A_CTRL   = AW'(6'h0C);
  localparam logic [AW-1:0] A_STAT   = AW'(6'h10);
  localparam logic [AW-1:0] A_RDATA  = AW'(6'h14);
  localparam logic [AW-1:0] A_WDATA  = AW'(6'h18);
  localparam logic [AW-1:0] A_FCTL   = AW'(6'h1C);
  localparam logic [AW-1:0] A_FSTAT  = AW'(6'h20);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [LW-1:0] level, level_nx;
  logic [3:0]    istate, istate_nx, ienable;
  logic          tx_en, rx_en;
  logic [LW-1:0] tx_thr;
  logic [2:0]    rx_thr;
  logic          rx_idle, rx_empty;
  logic [7:0]    rx_hold;

  wire wr       = req_valid & req_write;
  wire rd       = req_valid & ~req_write;
  wire full     = level == FULL_LVL;
  wire push_req = wr & (req_addr == A_WDATA);
  wire push     = push_req & ~full;
  wire flush    = wr & (req_addr == A_FCTL) & req_wdata[1];
  wire pop      = tx_valid & tx_ready;
  wire rx_take  = rx_valid & rx_en;
  wire tx_mt    = level == '0;

  assign tx_valid = tx_en & ~tx_mt;
  assign tx_byte  = mem[rptr];
  assign tx_drop  = push_req & full;
  assign irq      = istate & ienable;

  assign level_nx = flush ? '0 : level + LW'(push) - LW'(pop);

  wire wm_set    = push & (level_nx >= tx_thr);
  wire wm_clr    = (pop | flush) & (level_nx < tx_thr);
  wire empty_set = pop & ~push & (level == LW'(1));

  always_comb begin
    istate_nx = istate;
    if (wr && req_addr == A_ISTATE) istate_nx = istate_nx & ~req_wdata[3:0];
    if (wm_set)      istate_nx[0] = 1'b1;
    else if (wm_clr) istate_nx[0] = 1'b0;
    if (rx_take && rx_thr == '0) istate_nx[1] = 1'b1;
    if (empty_set)               istate_nx[2] = 1'b1;
    if (rx_take && !rx_empty)    istate_nx[3] = 1'b1;
    if (wr && req_addr == A_ITEST) istate_nx = istate_nx | req_wdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= req_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0;
      istate <= '0; ienable <= '0;
      tx_en <= 1'b0; rx_en <= 1'b0;
      tx_thr <= '0; rx_thr <= '0;
      rx_idle <= 1'b1; rx_empty <= 1'b1; rx_hold <= '0;
    end else begin
      level  <= level_nx;
      istate <= istate_nx;
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push) wptr <= wptr + PW'(1);
        if (pop)  rptr <= rptr + PW'(1);
      end
      if (wr && req_addr == A_IEN) ienable <= req_wdata[3:0];
      if (wr && req_addr == A_CTRL) begin
        tx_en <= req_wdata[0];
        rx_en <= req_wdata[1];
      end
      if (wr && req_addr == A_FCTL) begin
        tx_thr <= req_wdata[8 +: LW];
        rx_thr <= req_wdata[18:16];
      end
      if (rx_take) begin
        rx_hold  <= rx_byte;
        rx_idle  <= 1'b0;
        rx_empty <= 1'b0;
      end else if (rd && req_addr == A_RDATA) begin
        rx_idle  <= 1'b1;
        rx_empty <= 1'b1;
      end
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd) begin
      unique case (req_addr)
        A_ISTATE: rsp_rdata[3:0] = istate;
        A_IEN:    rsp_rdata[3:0] = ienable;
        A_CTRL:   rsp_rdata[1:0] = {rx_en, tx_en};
        A_STAT:   rsp_rdata[5:0] = {rx_empty, rx_idle, tx_mt, tx_mt, ~rx_empty, full};
        A_RDATA:  rsp_rdata[7:0] = rx_hold;
        A_FCTL: begin
          rsp_rdata[8 +: LW] = tx_thr;
          rsp_rdata[18:16]   = rx_thr;
        end
        A_FSTAT:  rsp_rdata[LW-1:0] = level;
        default:  rsp_rdata = '0;
      endcase
    end
  end

  p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drop && !pop) |=> (level == FULL_LVL));
  p_no_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !push && !flush) |=> $stable(level));
  p_empty_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level == LW'(1)) |=> istate[2]);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && tx_valid == 1'b0));
  p_test_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_ITEST) |=> ((istate & $past(req_wdata[3:0])) == $past(req_wdata[3:0])));
  p_pushpop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));
endmodule

// File: tb/uart_txq_bench.sv
`timescale 1ns/1ps
module uart_txq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        tx_valid, tx_drop;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  int drops = 0;
  logic [7:0] exp_q[$];
  logic [31:0] v;

  localparam logic [5:0] ISTATE = 6'h00, IEN = 6'h04, ITEST = 6'h08, CTRL = 6'h0C,
                         STAT = 6'h10, RDATA = 6'h14, WDATA = 6'h18, FCTL = 6'h1C,
                         FSTAT = 6'h20;

  uart_txq u_uart_txq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_drop(tx_drop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: a departure happens at the next edge
  always @(negedge clk) begin
    if (rst_n && tx_drop) drops++;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected byte", {24'b0, tx_byte}, 32'hFFFF_FFFF);
      else chk("R5 byte order", {24'b0, tx_byte}, {24'b0, exp_q.pop_front()});
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk); d = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    exp_q.push_back(b);
    wr(WDATA, {24'b0, b});
  endtask

  task automatic rx_in(logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(STAT, v);   chk("R1 status", v, 32'h3C);
    rd(ISTATE, v); chk("R1 istate", v, 0);
    rd(IEN, v);    chk("R1 enable", v, 0);
    rd(FSTAT, v);  chk("R1 level", v, 0);
    chk("R1 irq", {28'b0, irq}, 0);

    // R5 R7 threshold 4
    wr(FCTL, 32'h0000_0400);
    wr(IEN, 32'hF);
    push(8'h11); push(8'h22); push(8'h33);
    rd(FSTAT, v);  chk("R5 level 3", v, 3);
    rd(ISTATE, v); chk("R7 below threshold", v, 0);
    rd(STAT, v);   chk("R8 status non-empty", v, 32'h30);
    push(8'h44);
    rd(ISTATE, v); chk("R7 at threshold", v, 1);
    chk("R2 irq bit0", {28'b0, irq}, 1);

    // R3 R4 R2
    wr(ISTATE, 32'h1);
    rd(ISTATE, v); chk("R3 clear bit0", v, 0);
    wr(ITEST, 32'hF);
    rd(ISTATE, v); chk("R4 test set", v, 32'hF);
    wr(IEN, 32'h7);
    chk("R2 masked irq", {28'b0, irq}, 32'h7);
    wr(ISTATE, 32'hE);
    rd(ISTATE, v); chk("R3 partial clear", v, 1);

    // R8 no drain while disabled
    tx_ready = 1'b1;
    repeat (4) @(posedge clk); #1;
    rd(FSTAT, v); chk("R8 held while disabled", v, 4);

    // R8 R7 drain
    wr(CTRL, 32'h1);
    repeat (8) @(posedge clk); #1;
    rd(FSTAT, v);  chk("R8 drained", v, 0);
    chk("R5 queue consumed", exp_q.size(), 0);
    rd(ISTATE, v); chk("R7 R8 state after drain", v, 32'h4);
    rd(STAT, v);   chk("R8 status empty", v, 32'h3C);

    // R6 full and drop
    wr(CTRL, 32'h0);
    wr(ISTATE, 32'hF);
    for (int i = 0; i < 32; i++) push(8'h40 + 8'(i));
    rd(STAT, v);  chk("R6 full status", v, 32'h31);
    drops = 0;
    wr(WDATA, 32'hEE);
    rd(FSTAT, v); chk("R6 level after drop", v, 32);
    chk("R6 drop pulse", drops, 1);
    // full with a departure in the same cycle: still dropped
    wr(CTRL, 32'h1);
    tx_ready = 1'b0;
    exp_q.push_back(8'h0); exp_q.delete();
    for (int i = 0; i < 32; i++) exp_q.push_back(8'h40 + 8'(i));
    req_valid = 1'b1; req_write = 1'b1; req_addr = WDATA; req_wdata = 32'hEF; tx_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; tx_ready = 1'b0;
    chk("R6 drop with departure", drops, 2);
    rd(FSTAT, v); chk("R6 level after departure", v, 31);

    // R9 flush
    wr(FCTL, 32'h0000_0402);
    exp_q.delete();
    rd(FSTAT, v);  chk("R9 flushed level", v, 0);
    rd(STAT, v);   chk("R9 status", v, 32'h3C);
    rd(ISTATE, v); chk("R9 state", v, 0);

    // R12 write and departure in one cycle
    push(8'h71); push(8'h72);
    rd(FSTAT, v); chk("R12 level before", v, 2);
    exp_q.push_back(8'h73);
    req_valid = 1'b1; req_write = 1'b1; req_addr = WDATA; req_wdata = 32'h73; tx_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; tx_ready = 1'b0;
    rd(FSTAT, v); chk("R12 level unchanged", v, 2);
    tx_ready = 1'b1;
    repeat (4) @(posedge clk); #1;
    tx_ready = 1'b0;
    chk("R12 order kept", exp_q.size(), 0);
    rd(ISTATE, v); chk("R8 drained flag", v, 32'h4);

    // R10 R11 receive
    wr(ISTATE, 32'hF);
    wr(CTRL, 32'h2);
    rx_in(8'h5A);
    rd(STAT, v);   chk("R10 status after receive", v, 32'h0E);
    rd(ISTATE, v); chk("R11 rx threshold", v, 32'h2);
    rx_in(8'hA5);
    rd(ISTATE, v); chk("R11 overrun", v, 32'hA);
    chk("R2 irq rx", {28'b0, irq}, 32'h2);
    rd(RDATA, v);  chk("R10 holding", v, 32'hA5);
    rd(STAT, v);   chk("R11 status after read", v, 32'h3C);
    wr(CTRL, 32'h0);
    rx_in(8'h11);
    rd(RDATA, v);  chk("R10 ignored when disabled", v, 32'hA5);
    rd(STAT, v);   chk("R10 status when disabled", v, 32'h3C);
    wr(ISTATE, 32'hF);
    wr(FCTL, 32'h0002_0400);
    wr(CTRL, 32'h2);
    rx_in(8'h22);
    rd(ISTATE, v); chk("R11 rx threshold nonzero", v, 0);
    rd(RDATA, v);  chk("R10 new byte", v, 32'h22);

    finish_up();
  end
endmodule